// File: doc/BRIEF.md
# Inclusive Last-Level Cache Snoop Directory

This block is the tag-side directory of a shared last-level cache that holds every line present in the private caches of four cores. Each directory entry holds a tag, a valid flag and a presence vector with one bit per core. A bit is set whenever that core's private caches might hold the line. Bits are conservative: a private cache that drops a line without notice leaves its bit set, and the extra snoop that follows does no harm. Because the cache is inclusive, a directory miss proves that no core holds the line, so no core needs a probe.

One request is accepted per cycle. Each request carries an operation, a core number and an address, and gets a registered response one cycle later. The response gives the hit flag, the mask of other cores to snoop, and a flag that says the line may be held modified by exactly one other core. Fills allocate entries and grants update presence bits. Directory evictions, and fills that displace a valid line, issue a back-invalidate to the cores whose bits were set. Placement is 4-way set associative with least-recently-used replacement.

Top module: `snoop_dir`

## Requirements
- R1: Every cycle with `req_valid` high gives exactly one cycle of `rsp_valid` on the next cycle. A cycle without a request gives no response.
- R2: On a miss, `rsp_hit`, `rsp_snoop` and `rsp_may_mod` are all 0. The address's low SET_W bits select the set and the remaining high bits form the tag.
- R3: On a hit for lookup (op 0), fill (op 1) or grant (op 2), `rsp_snoop` is the line's presence vector with the requester's bit cleared (bit i is core i).
- R4: `rsp_may_mod` is 1 only when the line hits and its presence vector has exactly one bit set, and that bit belongs to a core other than the requester. When two or more bits are set, it is 0.
- R5: A fill that misses allocates the line with only the requester's bit set. A fill that hits acts as a shared grant.
- R6: A grant (op 2) that hits sets the requester's bit. With `req_excl` high, it instead leaves the requester's bit as the only bit set.
- R7: A grant that misses changes no state, so a later lookup of the same address still misses.
- R8: An eviction (op 3) that hits invalidates the line and raises `binv_valid` in the response cycle, with `binv_mask` equal to the line's vector and `binv_addr` equal to the line's address. An eviction that misses emits nothing.
- R9: A missing fill uses the lowest-numbered invalid way of the set. If the set is full, it uses the least-recently-used way. Hits by lookup, fill or grant, and allocations, all make that way the most recently used.
- R10: A fill that displaces a valid line emits a back-invalidate in the response cycle carrying the victim's vector and address.
- R11: After reset there is no response and no back-invalidate, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 lookup, 1 fill, 2 grant, 3 evict |
| req_core | input | 2 | Requesting core |
| req_excl | input | 1 | Exclusive grant |
| req_addr | input | 12 | Line address: tag above set index |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Line present in directory |
| rsp_snoop | output | 4 | Other cores to snoop |
| rsp_may_mod | output | 1 | Single other holder may have modified data |
| binv_valid | output | 1 | Back-invalidate strobe |
| binv_mask | output | 4 | Cores to invalidate |
| binv_addr | output | 12 | Address to invalidate |

## Verification
The assertions assume the request fields are stable and meaningful whenever `req_valid` is high. They also assume a fill is only issued for lines that a core is actually bringing in, so a presence vector never has all bits clear while the line is valid. The stimulus keeps to that rule: every line enters through a fill, and exclusive grants always leave the requester's bit set. Because of this, any back-invalidate carries a nonzero mask. The sequence uses two sets with distinct tags, so that hit, miss and replacement outcomes can be predicted by hand.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_FILL   = 2'd1,
    OP_GRANT  = 2'd2,
    OP_EVICT  = 2'd3
  } sf_op_e;
endpackage

// File: rtl/sf_tag_match.sv
module sf_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valids,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valids[w] && (tags[w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/sf_lru.sv
module sf_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_d;
  logic [WAY_W-1:0]           ref_age;

  always_comb begin
    ref_age = age_q[touch_set][touch_way];
    age_d   = age_q[touch_set];
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[touch_set][w] < ref_age) age_d[w] = age_q[touch_set][w] + 1'b1;
    end
    age_d[touch_way] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q[touch_set] <= age_d;
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[rd_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/snoop_dir.sv
module snoop_dir #(
  parameter int NC    = 4,
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CORE_W = $clog2(NC),
  localparam int ADDR_W = TAG_W + SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_excl,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [NC-1:0]     rsp_snoop,
  output logic              rsp_may_mod,
  output logic              binv_valid,
  output logic [NC-1:0]     binv_mask,
  output logic [ADDR_W-1:0] binv_addr
);
  import sf_pkg::*;

  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0][NC-1:0]    vec_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];

  sf_op_e           op;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic [WAY_W-1:0] hit_way, lru_way, free_way, victim, wr_way;
  logic             has_free;
  logic [NC-1:0]    req_bit, cur_vec, others, new_vec, vic_vec;
  logic             do_alloc, do_upd, do_evict, wr_en, touch_en;
  logic             q_op, vic_live;

  logic              rsp_valid_d, rsp_hit_d, rsp_may_mod_d, binv_valid_d;
  logic [NC-1:0]     rsp_snoop_d, binv_mask_d;
  logic [ADDR_W-1:0] binv_addr_d;

  assign op      = sf_op_e'(req_op);
  assign set_idx = req_addr[SET_W-1:0];
  assign tag     = req_addr[ADDR_W-1:SET_W];
  assign req_bit = NC'(1) << req_core;

  sf_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags(tag_q[set_idx]), .valids(valid_q[set_idx]), .tag(tag),
    .hit(hit), .hit_way(hit_way)
  );

  sf_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(set_idx),
    .touch_way(wr_way), .rd_set(set_idx), .victim_way(lru_way)
  );

  always_comb begin
    free_way = '0;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[set_idx][w]) begin
        free_way = WAY_W'(w);
        has_free = 1'b1;
      end
    end
  end

  assign victim   = has_free ? free_way : lru_way;
  assign cur_vec  = vec_q[set_idx][hit_way];
  assign others   = cur_vec & ~req_bit;
  assign vic_vec  = vec_q[set_idx][victim];
  assign vic_live = valid_q[set_idx][victim] && (vic_vec != '0);
  assign q_op     = (op != OP_EVICT);

  assign do_alloc = req_valid && (op == OP_FILL) && !hit;
  assign do_upd   = req_valid && hit && ((op == OP_FILL) || (op == OP_GRANT));
  assign do_evict = req_valid && hit && (op == OP_EVICT);
  assign wr_en    = do_alloc || do_upd || do_evict;
  assign wr_way   = do_alloc ? victim : hit_way;
  assign touch_en = do_alloc || (req_valid && hit && q_op);

  always_comb begin
    if (do_alloc)                            new_vec = req_bit;
    else if ((op == OP_GRANT) && req_excl)   new_vec = req_bit;
    else                                     new_vec = cur_vec | req_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[set_idx][wr_way] <= !do_evict;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !do_evict) begin
      tag_q[set_idx][wr_way] <= tag;
      vec_q[set_idx][wr_way] <= new_vec;
    end
  end

  always_comb begin
    rsp_valid_d   = req_valid;
    rsp_hit_d     = hit;
    rsp_snoop_d   = (hit && q_op) ? others : '0;
    rsp_may_mod_d = hit && q_op && ($countones(cur_vec) == 1) && (others != '0);
    binv_valid_d  = 1'b0;
    binv_mask_d   = '0;
    binv_addr_d   = '0;
    if (do_evict && (cur_vec != '0)) begin
      binv_valid_d = 1'b1;
      binv_mask_d  = cur_vec;
      binv_addr_d  = req_addr;
    end else if (do_alloc && vic_live) begin
      binv_valid_d = 1'b1;
      binv_mask_d  = vic_vec;
      binv_addr_d  = {tag_q[set_idx][victim], set_idx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      binv_valid <= 1'b0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      binv_valid <= binv_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit     <= 1'b0;
      rsp_snoop   <= '0;
      rsp_may_mod <= 1'b0;
      binv_mask   <= '0;
      binv_addr   <= '0;
    end else if (req_valid) begin
      rsp_hit     <= rsp_hit_d;
      rsp_snoop   <= rsp_snoop_d;
      rsp_may_mod <= rsp_may_mod_d;
      binv_mask   <= binv_mask_d;
      binv_addr   <= binv_addr_d;
    end
  end
endmodule

// File: rtl/sf_dir_chk.sv
module sf_dir_chk #(
  parameter int NC = 4,
  localparam int CORE_W = $clog2(NC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [CORE_W-1:0] req_core,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [NC-1:0]     rsp_snoop,
  input logic              rsp_may_mod,
  input logic              binv_valid,
  input logic [NC-1:0]     binv_mask
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_snoop == '0 && !rsp_may_mod));
  // R3
  no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((rsp_snoop & (NC'(1) << $past(req_core))) == '0));
  // R4
  single_holder_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_may_mod |-> ($countones(rsp_snoop) == 1));
  // R8
  binv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == 2'd0 || req_op == 2'd2) |=> !binv_valid);
  // R10
  binv_mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> (rsp_valid && binv_mask != '0));
endmodule

bind snoop_dir sf_dir_chk #(.NC(NC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_core(req_core), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_snoop(rsp_snoop), .rsp_may_mod(rsp_may_mod),
  .binv_valid(binv_valid), .binv_mask(binv_mask)
);

// File: tb/sim_snoop_dir.sv
module sim_snoop_dir;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_core = '0;
  logic        req_excl = 1'b0;
  logic [11:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_may_mod, binv_valid;
  logic [3:0]  rsp_snoop, binv_mask;
  logic [11:0] binv_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        hit;
    logic [3:0]  snoop;
    logic        mod;
    logic        bv;
    logic [3:0]  bmask;
    logic [11:0] baddr;
    string       req;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  snoop_dir u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_excl(req_excl), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_snoop(rsp_snoop),
    .rsp_may_mod(rsp_may_mod), .binv_valid(binv_valid),
    .binv_mask(binv_mask), .binv_addr(binv_addr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] core,
                       input logic [11:0] addr, input logic excl,
                       input logic hit, input logic [3:0] snoop, input logic mod,
                       input logic bv, input logic [3:0] bmask,
                       input logic [11:0] baddr, input string req);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_core = core;
    req_excl = excl; req_addr = addr;
    e.hit = hit; e.snoop = snoop; e.mod = mod;
    e.bv = bv; e.bmask = bmask; e.baddr = baddr; e.req = req;
    expq.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) begin
        check("R1", 1, 0, "unexpected response");
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(e.req, rsp_hit, e.hit, "hit");
        check(e.req, rsp_snoop, e.snoop, "snoop");
        check(e.req, rsp_may_mod, e.mod, "may_mod");
        check(e.req, binv_valid, e.bv, "binv_valid");
        if (e.bv) begin
          check(e.req, binv_mask, e.bmask, "binv_mask");
          check(e.req, binv_addr, e.baddr, "binv_addr");
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    check("R11", rsp_valid, 0, "rsp_valid in reset");
    check("R11", binv_valid, 0, "binv_valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R2 lookup of empty directory misses
    issue(2'd0, 2'd0, 12'h010, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R2");
    // R5 fill allocates with requester only
    issue(2'd1, 2'd0, 12'h010, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R5");
    // R3 R4 single other holder
    issue(2'd0, 2'd1, 12'h010, 0, 1, 4'h1, 1, 0, 4'h0, 12'h0, "R4");
    // R3 own bit only: no snoop
    issue(2'd0, 2'd0, 12'h010, 0, 1, 4'h0, 0, 0, 4'h0, 12'h0, "R3");
    // R6 shared grant adds core1
    issue(2'd2, 2'd1, 12'h010, 0, 1, 4'h1, 1, 0, 4'h0, 12'h0, "R6");
    // R4 two holders: not modified
    issue(2'd0, 2'd2, 12'h010, 0, 1, 4'h3, 0, 0, 4'h0, 12'h0, "R4");
    // R6 exclusive grant to core2
    issue(2'd2, 2'd2, 12'h010, 1, 1, 4'h3, 0, 0, 4'h0, 12'h0, "R6");
    issue(2'd0, 2'd0, 12'h010, 0, 1, 4'h4, 1, 0, 4'h0, 12'h0, "R6");
    // R7 grant on miss leaves state untouched
    issue(2'd2, 2'd3, 12'h020, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R7");
    issue(2'd0, 2'd3, 12'h020, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R7");
    // R8 eviction back-invalidates holders
    issue(2'd3, 2'd0, 12'h010, 0, 1, 4'h0, 0, 1, 4'h4, 12'h010, "R8");
    issue(2'd0, 2'd2, 12'h010, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R8");
    issue(2'd3, 2'd0, 12'h010, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R8");
    idle();
    @(negedge clk);
    // R1 no response while idle
    check("R1", rsp_valid, 0, "rsp_valid idle");
    // R9 fill set 1 with four lines
    issue(2'd1, 2'd0, 12'h011, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R9");
    issue(2'd1, 2'd1, 12'h021, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R9");
    issue(2'd1, 2'd2, 12'h031, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R9");
    issue(2'd1, 2'd3, 12'h041, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R9");
    issue(2'd0, 2'd1, 12'h011, 0, 1, 4'h1, 1, 0, 4'h0, 12'h0, "R9");
    // R10 victim is the least recently used line
    issue(2'd1, 2'd0, 12'h051, 0, 0, 4'h0, 0, 1, 4'h2, 12'h021, "R10");
    issue(2'd0, 2'd0, 12'h021, 0, 0, 4'h0, 0, 0, 4'h0, 12'h0, "R9");
    issue(2'd0, 2'd0, 12'h031, 0, 1, 4'h4, 1, 0, 4'h0, 12'h0, "R9");
    // R5 fill on hit acts as shared grant
    issue(2'd1, 2'd2, 12'h011, 0, 1, 4'h1, 1, 0, 4'h0, 12'h0, "R5");
    issue(2'd0, 2'd3, 12'h011, 0, 1, 4'h5, 0, 0, 4'h0, 12'h0, "R5");
    idle();
    repeat (3) @(negedge clk);
    check("R1", expq.size(), 0, "pending responses");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule